// File: doc/BRIEF.md
# Four-Pin GPIO Controller with Set/Clear Register Fields

This block controls four general-purpose pins from a single 32-bit configuration register. The register is reached through a dword address and four byte enables. Software never writes the output value or the drive direction of a pin directly. It changes them through write-1-to-set and write-1-to-clear fields, one pair for the output data and one pair for the output enable. A 1 in a set field raises the matching state bit, a 1 in a clear field lowers it, and a 0 leaves it alone. Several pins can therefore be changed in one write without a read-modify-write sequence.

The block drives two vectors to the pads: an output value and an output enable. A pin whose enable is low is an undriven input. The pad levels pass through one sampling register and then appear in a read-only field of the same word. Each set and clear field keeps a shadow copy of the value last written to it, and a read returns that copy.

Field layout of the register. Within every field, bit n controls pin n.

| Bits  | Field                   |
|-------|-------------------------|
| 7:0   | unused, read as 0       |
| 11:8  | output data clear       |
| 15:12 | output data set         |
| 19:16 | output enable clear     |
| 23:20 | output enable set       |
| 27:24 | reserved, read as 0     |
| 31:28 | sampled pad inputs      |

Top module: `gpio_setclr_reg`

## Requirements
- R1: While reset is asserted and just after it is released, padOut and padOe are all 0. Reading the register returns 0 in every bit, including the input field (bits 31:28).
- R2: An accepted write with a 1 in bit 12+n sets padOut[n] to 1.
- R3: An accepted write with a 1 in bit 8+n, and a 0 in bit 12+n, clears padOut[n] to 0.
- R4: A 1 in bit 20+n sets padOe[n] to 1. A 1 in bit 16+n, with a 0 in bit 20+n, clears padOe[n] to 0.
- R5: A 0 in any set or clear bit leaves the matching padOut or padOe bit unchanged.
- R6: When one write carries a 1 in both the set bit and the clear bit of a pin, the set bit wins. This holds for the data pair and for the enable pair.
- R7: A write is accepted only when cfgWrEn is high and cfgAddr equals REG_ADDR. Byte enable 1 gates the data fields (bits 15:8) and byte enable 2 gates the enable fields (bits 23:16). Writes to other addresses, and lanes whose byte enable is low, change nothing.
- R8: With cfgAddr equal to REG_ADDR, cfgRdData bits 11:8, 15:12, 19:16 and 23:20 return the value last written to each field, and bits 7:0 and 27:24 return 0. Any other address reads as 0.
- R9: Bits 31:28 of cfgRdData show padIn as sampled at the previous rising clock edge. Writes to byte lane 3 have no effect.
- R10: The effect of a write reaches padOut and padOe at the clock edge that accepts the write, so it is visible during the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write request for the current cycle |
| cfgAddr | input | ADDR_W | Dword address of the access |
| cfgByteEn | input | 4 | Byte-lane enables for the write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for cfgAddr (combinational) |
| padIn | input | GPIO_N | Pad input levels |
| padOut | output | GPIO_N | Pad output value |
| padOe | output | GPIO_N | Pad output enable (1 = driven) |

## Verification
The assertions assume that cfgWrEn, cfgAddr, cfgByteEn and cfgWrData are stable around each rising edge. They also assume that padIn is a clean level at the sampling edge, with no metastable value. The bench keeps to both rules: it changes every input only on the falling edge and leaves the whole rising half-cycle undisturbed. Random writes mix matching and non-matching addresses, arbitrary byte-enable patterns, and set and clear fields that overlap on the same pin. Pad inputs change in the same cycles as the writes.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

  // Number of pins served by the register.
  parameter int GPIO_N  = 4;

  // Width of the configuration data word.
  parameter int WORD_W  = 32;

  // Width of one field in the register word.
  parameter int FIELD_W = 4;

  // Field positions. Software depends on these, so they are fixed.
  parameter int DCLR_LSB  = 8;
  parameter int DSET_LSB  = 12;
  parameter int OECLR_LSB = 16;
  parameter int OESET_LSB = 20;
  parameter int RSV_LSB   = 24;
  parameter int IN_LSB    = 28;

  // Byte lanes that carry the writable fields.
  parameter int DATA_LANE = 1;
  parameter int OE_LANE   = 2;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic              rdHit;
    logic              dataWr;
    logic              oeWr;
    logic [GPIO_N-1:0] dataSet;
    logic [GPIO_N-1:0] dataClr;
    logic [GPIO_N-1:0] oeSet;
    logic [GPIO_N-1:0] oeClr;
  } strobeT;

endpackage

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_setclr_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 6'h19
) (
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [WORD_W-1:0] cfgWrData,
  output strobeT            strobe
);

  logic addrHit;
  logic wrHit;

  // Bits the decoder never looks at. Byte lane 3 holds only read-only fields.
  logic unusedBits;
  assign unusedBits = ^{cfgWrData[DCLR_LSB-1:0], cfgWrData[WORD_W-1:RSV_LSB],
                        cfgByteEn[0], cfgByteEn[3]};

  assign addrHit = (cfgAddr == REG_ADDR);
  assign wrHit   = cfgWrEn && addrHit;

  always_comb begin
    strobe         = '0;
    strobe.rdHit   = addrHit;
    strobe.dataWr  = wrHit && cfgByteEn[DATA_LANE];
    strobe.oeWr    = wrHit && cfgByteEn[OE_LANE];
    strobe.dataClr = cfgWrData[DCLR_LSB  +: GPIO_N];
    strobe.dataSet = cfgWrData[DSET_LSB  +: GPIO_N];
    strobe.oeClr   = cfgWrData[OECLR_LSB +: GPIO_N];
    strobe.oeSet   = cfgWrData[OESET_LSB +: GPIO_N];
  end

endmodule

// File: rtl/gpio_setclr_dp.sv
module gpio_setclr_dp
  import gpio_setclr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [GPIO_N-1:0] padIn,
  output logic [GPIO_N-1:0] padOut,
  output logic [GPIO_N-1:0] padOe,
  output logic [WORD_W-1:0] rdData
);

  localparam int PAD_W = FIELD_W - GPIO_N;

  // Applied pin state.
  logic [GPIO_N-1:0] dataQ;
  logic [GPIO_N-1:0] oeQ;

  // Shadow copies of the values last written to the four fields.
  logic [GPIO_N-1:0] shDataSet;
  logic [GPIO_N-1:0] shDataClr;
  logic [GPIO_N-1:0] shOeSet;
  logic [GPIO_N-1:0] shOeClr;

  // Single sampling stage for the pad inputs.
  logic [GPIO_N-1:0] padSync;

  // Per-pin update. On a write, the set bit takes priority over the clear bit.
  for (genvar p = 0; p < GPIO_N; p++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ[p] <= 1'b0;
      end else if (strobe.dataWr) begin
        if (strobe.dataSet[p]) begin
          dataQ[p] <= 1'b1;
        end else if (strobe.dataClr[p]) begin
          dataQ[p] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        oeQ[p] <= 1'b0;
      end else if (strobe.oeWr) begin
        if (strobe.oeSet[p]) begin
          oeQ[p] <= 1'b1;
        end else if (strobe.oeClr[p]) begin
          oeQ[p] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shDataSet <= '0;
      shDataClr <= '0;
    end else if (strobe.dataWr) begin
      shDataSet <= strobe.dataSet;
      shDataClr <= strobe.dataClr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shOeSet <= '0;
      shOeClr <= '0;
    end else if (strobe.oeWr) begin
      shOeSet <= strobe.oeSet;
      shOeClr <= strobe.oeClr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      padSync <= '0;
    end else begin
      padSync <= padIn;
    end
  end

  assign padOut = dataQ;
  assign padOe  = oeQ;

  // Read word assembly. The reserved field and the low byte read as 0.
  always_comb begin
    rdData = '0;
    if (strobe.rdHit) begin
      rdData[DCLR_LSB  +: FIELD_W] = {{PAD_W{1'b0}}, shDataClr};
      rdData[DSET_LSB  +: FIELD_W] = {{PAD_W{1'b0}}, shDataSet};
      rdData[OECLR_LSB +: FIELD_W] = {{PAD_W{1'b0}}, shOeClr};
      rdData[OESET_LSB +: FIELD_W] = {{PAD_W{1'b0}}, shOeSet};
      rdData[IN_LSB    +: FIELD_W] = {{PAD_W{1'b0}}, padSync};
    end
  end

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg
  import gpio_setclr_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 6'h19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [WORD_W-1:0] cfgRdData,
  input  logic [GPIO_N-1:0] padIn,
  output logic [GPIO_N-1:0] padOut,
  output logic [GPIO_N-1:0] padOe
);

  strobeT strobe;

  gpio_setclr_ctrl #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgByteEn (cfgByteEn),
    .cfgWrData (cfgWrData),
    .strobe    (strobe)
  );

  gpio_setclr_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .rdData (cfgRdData)
  );

endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk
  import gpio_setclr_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 6'h19
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [3:0]        cfgByteEn,
  input logic [WORD_W-1:0] cfgWrData,
  input logic [WORD_W-1:0] cfgRdData,
  input logic [GPIO_N-1:0] padIn,
  input logic [GPIO_N-1:0] padOut,
  input logic [GPIO_N-1:0] padOe
);

  logic dataLane;
  logic oeLane;
  logic pastValid;

  assign dataLane = cfgWrEn && (cfgAddr == REG_ADDR) && cfgByteEn[DATA_LANE];
  assign oeLane   = cfgWrEn && (cfgAddr == REG_ADDR) && cfgByteEn[OE_LANE];

  // Set once a full clock cycle has run out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (padOut == '0 && padOe == '0));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataLane |=> $stable(padOut));

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oeLane |=> $stable(padOe));

  // R6
  data_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataLane |=> ((padOut & $past(cfgWrData[DSET_LSB +: GPIO_N]))
                  == $past(cfgWrData[DSET_LSB +: GPIO_N])));

  // R3
  data_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataLane |=> ((padOut & $past(cfgWrData[DCLR_LSB +: GPIO_N])
                   & ~$past(cfgWrData[DSET_LSB +: GPIO_N])) == '0));

  // R4
  oe_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeLane |=> ((padOe & $past(cfgWrData[OESET_LSB +: GPIO_N]))
                == $past(cfgWrData[OESET_LSB +: GPIO_N])));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[RSV_LSB +: FIELD_W] == '0) && (cfgRdData[DCLR_LSB-1:0] == '0));

  // R9
  input_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && cfgAddr == REG_ADDR) |->
      (cfgRdData[IN_LSB +: GPIO_N] == $past(padIn)));

endmodule

bind gpio_setclr_reg gpio_setclr_chk #(
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgAddr   (cfgAddr),
  .cfgByteEn (cfgByteEn),
  .cfgWrData (cfgWrData),
  .cfgRdData (cfgRdData),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOe     (padOe)
);

// File: tb/gpio_setclr_reg_bench.sv
module gpio_setclr_reg_bench;

  localparam logic [5:0] REG = 6'h19;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [5:0]  cfgAddr;
  logic [3:0]  cfgByteEn;
  logic [31:0] cfgWrData;
  logic [31:0] cfgRdData;
  logic [3:0]  padIn;
  logic [3:0]  padOut;
  logic [3:0]  padOe;

  int errors = 0;
  int checks = 0;

  // Model of the register state.
  logic [3:0] expOut, expOe, expIn;
  logic [3:0] shDS, shDC, shOS, shOC;

  always #2.5 clk = ~clk;

  gpio_setclr_reg u_gpio_setclr_reg (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgByteEn (cfgByteEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe)
  );

  function automatic logic [31:0] expWord();
    return {expIn, 4'h0, shOS, shOC, shDS, shDC, 8'h00};
  endfunction

  function automatic logic [3:0] applySetClr(logic [3:0] cur, logic [3:0] s, logic [3:0] c);
    return (cur & ~c) | s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One access cycle. Inputs are driven on the falling edge; results are
  // checked on the following falling edge.
  task automatic cycle(string tag, logic we, logic [5:0] a, logic [3:0] be,
                       logic [31:0] wd, logic [3:0] pin);
    cfgWrEn = we; cfgAddr = a; cfgByteEn = be; cfgWrData = wd; padIn = pin;
    #1;
    // R9: a new pad level is not visible before the sampling edge.
    if (a == REG) check("R9 latency", {28'h0, cfgRdData[31:28]}, {28'h0, expIn});
    @(posedge clk);
    if (we && a == REG && be[1]) begin
      expOut = applySetClr(expOut, wd[15:12], wd[11:8]);
      shDS = wd[15:12]; shDC = wd[11:8];
    end
    if (we && a == REG && be[2]) begin
      expOe = applySetClr(expOe, wd[23:20], wd[19:16]);
      shOS = wd[23:20]; shOC = wd[19:16];
    end
    expIn = pin;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgAddr = REG;
    #1;
    check({tag, " padOut"}, {28'h0, padOut}, {28'h0, expOut});
    check({tag, " padOe"},  {28'h0, padOe},  {28'h0, expOe});
    check("R8 read word", cfgRdData, expWord());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = REG; cfgByteEn = 4'h0;
    cfgWrData = '0; padIn = 4'hA;
    expOut = '0; expOe = '0; expIn = '0;
    shDS = '0; shDC = '0; shOS = '0; shOC = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 padOut", {28'h0, padOut}, 32'h0);
    check("R1 padOe",  {28'h0, padOe},  32'h0);
    check("R1 read",   cfgRdData,       32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 after release", {24'h0, padOut, padOe}, 32'h0);

    // Directed corner cases.
    cycle("R2",  1'b1, REG, 4'b0010, 32'h0000_F000, 4'h0);
    cycle("R4",  1'b1, REG, 4'b0100, 32'h00F0_0000, 4'h5);
    cycle("R3",  1'b1, REG, 4'b0010, 32'h0000_0500, 4'h5);
    cycle("R5",  1'b1, REG, 4'b0110, 32'h0000_0000, 4'h3);
    cycle("R6",  1'b1, REG, 4'b0110, 32'h0036_3F00, 4'h3);
    cycle("R7",  1'b1, REG, 4'b1001, 32'hFFFF_FFFF, 4'hC);
    cycle("R7",  1'b1, 6'h18, 4'b1111, 32'h00F0_0F00, 4'hC);
    cycle("R7",  1'b0, REG, 4'b1111, 32'h000F_00F0, 4'h9);
    cycle("R9",  1'b1, REG, 4'b1000, 32'hFF00_0000, 4'h6);
    cycle("R4",  1'b1, REG, 4'b0100, 32'h000A_0000, 4'h6);
    cycle("R10", 1'b1, REG, 4'b0110, 32'h0050_A000, 4'hF);

    // R8: a different address reads as 0.
    cfgAddr = 6'h00;
    #1;
    check("R8 other address", cfgRdData, 32'h0);
    @(negedge clk);

    // Random phase.
    for (int i = 0; i < 400; i++) begin
      logic [5:0] a;
      a = ($urandom % 8 == 0) ? 6'($urandom) : REG;
      cycle("R2", ($urandom % 4) != 0, a, 4'($urandom), $urandom, 4'($urandom));
    end

    summary();
  end

endmodule